// File: doc/BRIEF.md
# PS/2 Device-to-Host Byte Receiver

This block takes the open-collector clock and data lines of a PS/2 mouse or keyboard, as seen by the host, and turns each frame that the device sends into a byte on the system clock. Both lines pass through a two-stage synchronizer. The block treats a falling edge of the device clock as real only once the synchronized clock has stayed low for a set number of system cycles. This lets it ignore short glitches on the cable.

A frame has eleven bit slots. It begins with a low start bit, followed by eight data bits with the least significant bit first. Then comes a parity bit that makes the number of ones among data and parity odd, and last a high stop bit. When a frame ends, the byte appears on `rx_byte` with a one-cycle `rx_valid` pulse. `rx_err` pulses in the same cycle if the parity or the stop bit is wrong.

A start slot that reads high leaves the receiver idle. If a frame is cut short, a silence counter returns the receiver to idle, so the next frame is received correctly. The block never drives the bus and does not decode the bytes it receives.

Top module: `ps2_frame_receiver`

## Requirements
- R1: After reset, `rx_valid` and `rx_err` are 0 and `rx_byte` is 8'h00.
- R2: A well-formed frame delivers its eight data bits with the least significant bit first on `rx_byte`, together with a `rx_valid` pulse exactly one cycle wide.
- R3: When data and parity contain an odd number of ones, `rx_err` stays 0. When the count is even, `rx_err` pulses in the same cycle as `rx_valid`, and `rx_byte` still carries the received data.
- R4: A stop slot that reads 0 makes `rx_err` pulse in the same cycle as `rx_valid`.
- R5: A device-clock falling edge while idle with data high is not taken as a start bit. No pulse follows, and the next proper frame is received intact.
- R6: A low excursion of the synchronized device clock shorter than `FILT_CYCLES` system cycles is not counted as a bit.
- R7: Inside a frame, if `TIMEOUT_CYCLES` system cycles pass without an accepted falling edge, the receiver returns to idle. A frame sent afterwards is received intact.
- R8: Frames sent back to back, each directly after the previous stop bit, are each delivered in order with one pulse apiece.
- R9: `rx_valid` goes high just after the (`FILT_CYCLES`+2)-th rising system-clock edge, counted from the moment the device clock drops in the stop slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_in | input | 1 | Device clock line level (asynchronous) |
| ps2_dat_in | input | 1 | Device data line level (asynchronous) |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_err | output | 1 | One-cycle pulse with `rx_valid` on a parity or stop failure |

## Verification
Each accepted falling edge takes effect after a fixed delay: two synchronizer stages plus `FILT_CYCLES` filter cycles. The byte, the valid pulse and the error pulse therefore all appear just after the (`FILT_CYCLES`+2)-th rising edge after the stop-slot clock drop. The bench records the cycle count when it drives that drop and the cycle count when it first sees the pulse, sampling on falling system-clock edges, and requires the difference to equal that figure. For the other checks it waits a margin of several cycles after each frame, then compares the number of pulses, the captured byte and the error flag. Any pulse longer than one cycle is counted separately.

// File: rtl/ps2_frame_receiver.sv
`timescale 1ns/1ps
module ps2_frame_receiver #(
  parameter int FILT_CYCLES    = 8,
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err
);
  localparam int LW = $clog2(FILT_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic          c_s1, c_s2, d_s1, d_s2;
  logic [LW-1:0] low_cnt;
  logic [TW-1:0] quiet_cnt;
  logic [3:0]    bit_idx;
  logic [7:0]    shreg;
  logic          par_bit;

  wire fall    = !c_s2 && (low_cnt == LW'(FILT_CYCLES - 1));
  wire expired = (bit_idx != 4'd0) && (quiet_cnt == TW'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_s1 <= 1'b1; c_s2 <= 1'b1;
      d_s1 <= 1'b1; d_s2 <= 1'b1;
    end else begin
      c_s1 <= ps2_clk_in; c_s2 <= c_s1;
      d_s1 <= ps2_dat_in; d_s2 <= d_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || c_s2)
      low_cnt <= '0;
    else if (low_cnt != LW'(FILT_CYCLES))
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bit_idx == 4'd0 || fall)
      quiet_cnt <= '0;
    else
      quiet_cnt <= quiet_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx  <= 4'd0;
      shreg    <= 8'h00;
      par_bit  <= 1'b0;
      rx_byte  <= 8'h00;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (fall) begin
        if (bit_idx == 4'd0) begin
          if (!d_s2) bit_idx <= 4'd1;
        end else if (bit_idx <= 4'd8) begin
          shreg   <= {d_s2, shreg[7:1]};
          bit_idx <= bit_idx + 4'd1;
        end else if (bit_idx == 4'd9) begin
          par_bit <= d_s2;
          bit_idx <= 4'd10;
        end else begin
          rx_byte  <= shreg;
          rx_valid <= 1'b1;
          rx_err   <= !(^{shreg, par_bit}) || !d_s2;
          bit_idx  <= 4'd0;
        end
      end else if (expired) begin
        bit_idx <= 4'd0;
      end
    end
  end

  a_r3_err_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_valid);
  a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 4'd10);
  a_r5_high_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == 4'd0 && fall && d_s2) |=> (bit_idx == 4'd0));
  a_r7_timeout_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !fall) |=> (bit_idx == 4'd0));
endmodule

// File: tb/ps2_frame_receiver_bench.sv
`timescale 1ns/1ps
module ps2_frame_receiver_bench;
  localparam int FILT = 4;
  localparam int TOUT = 300;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pclk = 1'b1;
  logic pdat = 1'b1;
  logic [7:0] rx_byte;
  logic rx_valid, rx_err;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int pulses = 0, wide = 0, v_cyc = 0, stop_cyc = 0;
  logic [7:0] got_byte = 8'h00;
  logic got_err = 1'b0;
  logic prev_v = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ps2_frame_receiver #(.FILT_CYCLES(FILT), .TIMEOUT_CYCLES(TOUT)) u_ps2_frame_receiver (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(pclk), .ps2_dat_in(pdat),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid && !prev_v) begin
      pulses   = pulses + 1;
      got_byte = rx_byte;
      got_err  = rx_err;
      v_cyc    = cyc;
    end
    if (rx_valid && prev_v) wide = wide + 1;
    prev_v = rx_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_slot(input logic bitv, input bit glitch);
    pdat = bitv;
    if (glitch) begin
      wait_cyc(HALF/4);
      pclk = 1'b0; wait_cyc(2); pclk = 1'b1;
      wait_cyc(HALF - HALF/4 - 2);
    end else
      wait_cyc(HALF);
    pclk = 1'b0;
    wait_cyc(HALF);
    pclk = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input logic stopv, input bit glitch);
    logic par;
    par = bad_par ? ^b : ~^b;
    drive_slot(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_slot(b[i], glitch && i == 3);
    drive_slot(par, 1'b0);
    pdat = stopv;
    wait_cyc(HALF);
    pclk = 1'b0;
    stop_cyc = cyc;
    wait_cyc(HALF);
    pclk = 1'b1;
    pdat = 1'b1;
  endtask

  task automatic expect_one(input string req, input logic [7:0] b, input logic e, input int p0);
    wait_cyc(FILT + 8);
    chk({req, " pulse count"}, pulses - p0, 1);
    chk({req, " byte"}, got_byte, b);
    chk({req, " error flag"}, got_err, e);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", rx_valid, 0);
    chk("R1 err after reset", rx_err, 0);
    chk("R1 byte after reset", rx_byte, 8'h00);
  endtask

  task automatic t_basic;
    int p0;
    p0 = pulses; send(8'hA5, 0, 1'b1, 0); expect_one("R2 R3 A5", 8'hA5, 1'b0, p0);
    chk("R9 latency", v_cyc - stop_cyc, FILT + 2);
    p0 = pulses; send(8'h01, 0, 1'b1, 0); expect_one("R2 LSB first 01", 8'h01, 1'b0, p0);
    p0 = pulses; send(8'h80, 0, 1'b1, 0); expect_one("R2 80", 8'h80, 1'b0, p0);
    p0 = pulses; send(8'h00, 0, 1'b1, 0); expect_one("R3 all zero", 8'h00, 1'b0, p0);
    chk("R2 pulse width", wide, 0);
  endtask

  task automatic t_errors;
    int p0;
    p0 = pulses; send(8'h3C, 1, 1'b1, 0); expect_one("R3 bad parity", 8'h3C, 1'b1, p0);
    p0 = pulses; send(8'hC3, 0, 1'b0, 0); expect_one("R4 low stop", 8'hC3, 1'b1, p0);
    p0 = pulses; send(8'h5A, 0, 1'b1, 0); expect_one("R3 clean after error", 8'h5A, 1'b0, p0);
  endtask

  task automatic t_high_start;
    int p0;
    p0 = pulses;
    drive_slot(1'b1, 1'b0);
    wait_cyc(FILT + 8);
    chk("R5 no pulse from high start", pulses - p0, 0);
    send(8'h96, 0, 1'b1, 0); expect_one("R5 next frame", 8'h96, 1'b0, p0);
  endtask

  task automatic t_glitch;
    int p0;
    p0 = pulses; send(8'h6B, 0, 1'b1, 1); expect_one("R6 glitch ignored", 8'h6B, 1'b0, p0);
  endtask

  task automatic t_timeout;
    int p0;
    p0 = pulses;
    drive_slot(1'b0, 1'b0);
    drive_slot(1'b1, 1'b0);
    drive_slot(1'b0, 1'b0);
    drive_slot(1'b1, 1'b0);
    wait_cyc(TOUT + 50);
    chk("R7 no pulse from cut frame", pulses - p0, 0);
    send(8'hE7, 0, 1'b1, 0); expect_one("R7 after timeout", 8'hE7, 1'b0, p0);
  endtask

  task automatic t_burst;
    int p0;
    logic [7:0] seq [3];
    seq[0] = 8'h08; seq[1] = 8'h04; seq[2] = 8'h05;
    p0 = pulses;
    for (int k = 0; k < 3; k++) begin
      send(seq[k], 0, 1'b1, 0);
      wait_cyc(FILT + 4);
      chk("R8 burst count", pulses - p0, k + 1);
      chk("R8 burst byte", got_byte, seq[k]);
      wait_cyc(HALF - FILT - 4);
    end
    chk("R8 burst pulse width", wide, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset;
    wait_cyc(20);
    t_basic;
    t_errors;
    t_high_start;
    t_glitch;
    t_timeout;
    t_burst;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule